// File: doc/BRIEF.md
# Interrupt Acknowledge Capture Unit

This block is a test agent on the processor side of an interrupt controller. It watches the request line, runs the two-pulse interrupt acknowledge handshake itself, and keeps what the controller puts on the bus during the second pulse: an 8-bit vector type and a 3-bit cascade code. It never branches to a handler. The captured data waits in the unit until a host reads it.

Capture is one-shot. When a capture completes, the unit raises a vector-available flag, and while that flag is set, further requests go unanswered. A host clears the flag with one read address, which also returns the type. A second read address returns the same type and leaves the flag alone. A third read address returns the cascade code. A host write can force a handshake at any time the sequencer is idle. A one-bit enable setting, on after reset, gates automatic acknowledgement.

A sync output marks the handshake for test equipment. In scope mode it covers the whole two-pulse sequence. In probe mode it is a single pulse once the second acknowledge has ended.

Top module: `iack_capture_unit`

## Requirements
- R1: After reset, inta_o and sync_o are low, the status word is 0 apart from live bits, and automatic acknowledgement is enabled.
- R2: A handshake is two acknowledge pulses on inta_o. Each pulse is high for ACK_CLKS clocks (default 3), and the two are separated by GAP_CLKS low clocks (default 2, at least 1).
- R3: The type and cascade code are sampled from vec_i and cas_i in the last clock of the second pulse. Values present during the first pulse are not kept. Host address 2 returns the type in bits 7:0, and address 3 returns the cascade code in bits 2:0.
- R4: Completing a capture sets status bit 11 (vector available). While that bit is set, a high irq_i starts no handshake.
- R5: A read of host address 1 returns the type in bits 7:0 and clears status bit 11. A request that is still pending is then acknowledged.
- R6: A read of host address 2 leaves status bit 11 set.
- R7: A write of any data to host address 1 starts a handshake on the next clock when the sequencer is idle. This happens even if bit 11 is set or acknowledgement is disabled, and it overwrites the capture.
- R8: A write to host address 0 sets the auto-acknowledge enable from host_wdata_i (1 = enabled). While disabled, irq_i starts no handshake.
- R9: With sync_probe_i = 0, sync_o is high in exactly the clocks from the first clock of the first pulse through the last clock of the second pulse.
- R10: With sync_probe_i = 1, sync_o is a single-clock pulse in the clock that follows the last clock of the second pulse. It is low otherwise.
- R11: Status (host address 0) carries live inputs: bit 0 ready_i, bit 3 irq_i, bit 4 tgt_reset_i. All other bits apart from bit 11 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request from the controller |
| ready_i | input | 1 | Live bus-ready input, shown in status |
| tgt_reset_i | input | 1 | Live target reset input, shown in status |
| sync_probe_i | input | 1 | Sync mode: 0 scope, 1 probe |
| inta_o | output | 1 | Interrupt acknowledge strobe, active high |
| vec_i | input | 8 | Vector type driven by the controller |
| cas_i | input | 3 | Cascade code driven by the controller |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 1 | Host write data (enable setting) |
| host_rdata_o | output | 16 | Host read data, combinational from address |
| sync_o | output | 1 | Scope or probe sync output |

## Verification
A lockout flag stuck high would silence inta_o for good. One that fails to set would let inta_o repeat within a few clocks of a capture while irq_i stays high. A sequencer counter that is off by one shows up at once as a wrong pulse or gap width, which the bench measures in clocks. A capture taken in the wrong pulse returns the responder's deliberately wrong first-pulse value on the very next host read. Sync errors show in the same handshake, one clock early or late against inta_o.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int TYPE_W = 8;
    localparam int CAS_W  = 3;
    localparam int STAT_W = 16;

    localparam int ST_READY  = 0;
    localparam int ST_IRQ    = 3;
    localparam int ST_TRESET = 4;
    localparam int ST_VAVAIL = 11;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACK1 = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_ACK2 = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        HA_STATUS = 2'd0,
        HA_REARM  = 2'd1,
        HA_PEEK   = 2'd2,
        HA_CASC   = 2'd3
    } host_addr_e;

    typedef struct packed {
        logic [TYPE_W-1:0] vtype;
        logic [CAS_W-1:0]  casc;
    } capture_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic vavail, input logic treset, input logic irq, input logic rdy);
        logic [STAT_W-1:0] s;
        s = '0;
        s[ST_VAVAIL] = vavail;
        s[ST_TRESET] = treset;
        s[ST_IRQ]    = irq;
        s[ST_READY]  = rdy;
        return s;
    endfunction

endpackage

// File: rtl/iack_sequencer.sv
module iack_sequencer
    import iack_pkg::*;
#(
    parameter int ACK_CLKS = 3,
    parameter int GAP_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic inta,
    output logic busy,
    output logic start,
    output logic finish
);
    localparam int MAXC  = (ACK_CLKS > GAP_CLKS) ? ACK_CLKS : GAP_CLKS;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);

    seq_state_e state;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        start  = (state == SEQ_IDLE) && go;
        finish = (state == SEQ_ACK2) && (cnt == ACK_LAST);
        inta   = (state == SEQ_ACK1) || (state == SEQ_ACK2);
        busy   = (state != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (go) begin
                    state <= SEQ_ACK1;
                    cnt   <= '0;
                end
                SEQ_ACK1: if (cnt == ACK_LAST) begin
                    state <= SEQ_GAP;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                SEQ_GAP: if (cnt == GAP_LAST) begin
                    state <= SEQ_ACK2;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                default: if (cnt == ACK_LAST) begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
            endcase
        end
    end

    // R2: the first pulse never runs straight into the second
    assert_gap_present_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_ACK1) |=> (state != SEQ_ACK2));

    // R2: a handshake, once begun, leaves idle on the next clock
    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> inta);

endmodule

// File: rtl/iack_capture.sv
module iack_capture
    import iack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              finish,
    input  logic              rearm,
    input  logic [TYPE_W-1:0] vec_i,
    input  logic [CAS_W-1:0]  cas_i,
    output logic              vavail,
    output capture_t          cap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vavail <= 1'b0;
            cap    <= '0;
        end else begin
            if (finish) begin
                cap.vtype <= vec_i;
                cap.casc  <= cas_i;
                vavail    <= 1'b1;
            end else if (rearm) begin
                vavail <= 1'b0;
            end
        end
    end

    // R5: a re-arm read with no capture in flight clears the flag
    assert_rearm_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rearm && !finish) |=> !vavail);

    // R3: the captured data holds between captures
    assert_capture_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(cap));

endmodule

// File: rtl/iack_sync.sv
module iack_sync (
    input  logic clk,
    input  logic rst,
    input  logic probe_mode,
    input  logic start,
    input  logic busy,
    input  logic finish,
    output logic sync_o
);
    always_ff @(posedge clk) begin
        if (rst) sync_o <= 1'b0;
        else if (probe_mode) sync_o <= finish;
        else sync_o <= start || (busy && !finish);
    end

    // R10: the probe pulse lasts a single clock
    assert_probe_single_R10: assert property (@(posedge clk) disable iff (rst)
        (probe_mode && $past(probe_mode) && sync_o) |=> !sync_o);

    // R9: scope sync covers the handshake while the mode is steady
    assert_scope_cover_R9: assert property (@(posedge clk) disable iff (rst)
        (!probe_mode && $past(!probe_mode) && busy) |-> sync_o);

endmodule

// File: rtl/iack_capture_unit.sv
module iack_capture_unit
    import iack_pkg::*;
#(
    parameter int ACK_CLKS = 3,
    parameter int GAP_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_i,
    input  logic        ready_i,
    input  logic        tgt_reset_i,
    input  logic        sync_probe_i,
    output logic        inta_o,
    input  logic [7:0]  vec_i,
    input  logic [2:0]  cas_i,
    input  logic        host_rd_i,
    input  logic        host_wr_i,
    input  logic [1:0]  host_addr_i,
    input  logic        host_wdata_i,
    output logic [15:0] host_rdata_o,
    output logic        sync_o
);
    logic     go, busy, start, finish, vavail, int_en, force_req, rearm;
    capture_t cap;

    always_comb begin
        force_req = host_wr_i && (host_addr_i == HA_REARM);
        rearm     = host_rd_i && (host_addr_i == HA_REARM);
        go        = force_req || (irq_i && !vavail && int_en);
    end

    always_ff @(posedge clk) begin
        if (rst) int_en <= 1'b1;
        else if (host_wr_i && host_addr_i == HA_STATUS) int_en <= host_wdata_i;
    end

    iack_sequencer #(.ACK_CLKS(ACK_CLKS), .GAP_CLKS(GAP_CLKS)) u_seq (
        .clk(clk), .rst(rst), .go(go), .inta(inta_o),
        .busy(busy), .start(start), .finish(finish));

    iack_capture u_cap (
        .clk(clk), .rst(rst), .finish(finish), .rearm(rearm),
        .vec_i(vec_i), .cas_i(cas_i), .vavail(vavail), .cap(cap));

    iack_sync u_sync (
        .clk(clk), .rst(rst), .probe_mode(sync_probe_i), .start(start),
        .busy(busy), .finish(finish), .sync_o(sync_o));

    always_comb begin
        case (host_addr_i)
            HA_STATUS: host_rdata_o = pack_status(vavail, tgt_reset_i, irq_i, ready_i);
            HA_REARM,
            HA_PEEK:   host_rdata_o = {{(STAT_W-TYPE_W){1'b0}}, cap.vtype};
            default:   host_rdata_o = {{(STAT_W-CAS_W){1'b0}}, cap.casc};
        endcase
    end

    // R4: with the flag set and no force, an idle unit stays idle
    assert_lockout_R4: assert property (@(posedge clk) disable iff (rst)
        (vavail && !force_req && !busy) |=> !busy);

    // R8: auto acknowledge disabled keeps an idle unit idle without a force
    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
        (!int_en && !force_req && !busy) |=> !busy);

    // R6: a peek read leaves the flag set
    assert_peek_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (vavail && host_rd_i && host_addr_i == HA_PEEK) |=> vavail);

    // R7: a force while idle begins a handshake
    assert_force_starts_R7: assert property (@(posedge clk) disable iff (rst)
        (force_req && !busy) |=> inta_o);

endmodule

// File: tb/iack_capture_unit_bench.sv
module iack_capture_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0, rdy = 1'b0, trst = 1'b0, probe = 1'b0;
    logic inta, syn;
    logic rd = 1'b0, wr = 1'b0, wd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [15:0] rdata;
    logic [7:0] exp_type = 8'h00;
    logic [2:0] exp_cas = 3'd0;
    logic phase = 1'b0, inta_prev = 1'b0;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    // responder: wrong data during the first pulse, real data in the second
    always @(negedge clk) begin
        if (inta && !inta_prev) phase <= ~phase;
        inta_prev <= inta;
    end
    wire [7:0] vec_drv = phase ? ~exp_type : exp_type;
    wire [2:0] cas_drv = phase ? ~exp_cas : exp_cas;

    iack_capture_unit u_iack_capture_unit (
        .clk(clk), .rst(rst), .irq_i(irq), .ready_i(rdy), .tgt_reset_i(trst),
        .sync_probe_i(probe), .inta_o(inta), .vec_i(vec_drv), .cas_i(cas_drv),
        .host_rd_i(rd), .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wd),
        .host_rdata_o(rdata), .sync_o(syn));

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic int stat(input bit va, input bit tr, input bit iq, input bit ry);
        return (int'(va) << 11) | (int'(tr) << 4) | (int'(iq) << 3) | int'(ry);
    endfunction

    task automatic hread(input logic [1:0] a, output int v);
        rd = 1'b1; addr = a;
        #1 v = int'(rdata);
        @(negedge clk); rd = 1'b0; addr = 2'd0;
    endtask

    task automatic hwrite(input logic [1:0] a, input logic d);
        wr = 1'b1; addr = a; wd = d;
        @(negedge clk); wr = 1'b0; addr = 2'd0;
    endtask

    // measures one handshake at falling edges; R2, R9, R10
    task automatic run_seq();
        int w = 0, h1 = 0, g = 0, h2 = 0, sbad = 0;
        while (!inta && w < 20) begin @(negedge clk); w++; end
        while (inta && h1 < 20) begin
            if (syn !== !probe) sbad++;
            h1++; @(negedge clk);
        end
        while (!inta && g < 20) begin
            if (syn !== !probe) sbad++;
            g++; @(negedge clk);
        end
        while (inta && h2 < 20) begin
            if (syn !== !probe) sbad++;
            h2++; @(negedge clk);
        end
        chk("R2 first pulse width", h1, 3);
        chk("R2 gap width", g, 2);
        chk("R2 second pulse width", h2, 3);
        chk(probe ? "R10 sync low during handshake" : "R9 sync over handshake", sbad, 0);
        chk(probe ? "R10 probe pulse after end" : "R9 sync falls at end", int'(syn), int'(probe));
        @(negedge clk);
        chk("R10 sync single clock", int'(syn), 0);
    endtask

    task automatic no_ack(input string req);
        int seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (inta) seen++;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 inta low", int'(inta), 0);
        chk("R1 sync low", int'(syn), 0);
        hread(2'd0, v); chk("R1 status", v, 0);

        // R11 live status bits
        for (int p = 0; p < 4; p++) begin
            rdy = p[0]; trst = p[1];
            hread(2'd0, v); chk("R11 live status", v, stat(0, p[1], 0, p[0]));
        end
        rdy = 1'b0; trst = 1'b0;

        // sweep: both sync modes, several type/cascade patterns
        for (int m = 0; m < 2; m++) begin
            probe = m[0];
            for (int i = 0; i < 4; i++) begin
                exp_type = 8'((i * 71 + m * 29 + 5) & 255);
                exp_cas  = 3'((i * 3 + m + 1) & 7);
                irq = 1'b1;
                run_seq();
                hread(2'd0, v); chk("R4 R11 flag and irq in status", v, stat(1, 0, 1, 0));
                no_ack("R4 lockout with irq high");
                irq = 1'b0;
                hread(2'd2, v); chk("R3 peek type", v, int'(exp_type));
                hread(2'd0, v); chk("R6 flag kept after peek", v, stat(1, 0, 0, 0));
                hread(2'd3, v); chk("R3 cascade code", v, int'(exp_cas));
                hread(2'd1, v); chk("R5 rearm returns type", v, int'(exp_type));
                hread(2'd0, v); chk("R5 flag cleared", v, stat(0, 0, 0, 0));
            end
        end

        // R5: pending request is acknowledged after re-arm
        probe = 1'b0;
        exp_type = 8'hC3; exp_cas = 3'd6; irq = 1'b1;
        run_seq();
        hread(2'd1, v); chk("R5 rearm type", v, 8'hC3);
        exp_type = 8'h3C; exp_cas = 3'd1;
        run_seq();
        irq = 1'b0;
        hread(2'd1, v); chk("R5 re-acknowledged type", v, 8'h3C);

        // R7: force while flag set overwrites the capture
        irq = 1'b1; exp_type = 8'h11; exp_cas = 3'd2;
        run_seq();
        irq = 1'b0;
        exp_type = 8'hEE; exp_cas = 3'd5;
        hwrite(2'd1, 1'b0);
        run_seq();
        hread(2'd2, v); chk("R7 forced capture type", v, 8'hEE);
        hread(2'd3, v); chk("R7 forced capture cascade", v, 5);
        hread(2'd1, v);

        // R8: disabled auto acknowledge, force still works, re-enable resumes
        hwrite(2'd0, 1'b0);
        irq = 1'b1;
        no_ack("R8 no ack while disabled");
        hread(2'd0, v); chk("R8 flag clear while disabled", v, stat(0, 0, 1, 0));
        exp_type = 8'h5A; exp_cas = 3'd3;
        hwrite(2'd1, 1'b1);
        run_seq();
        hread(2'd1, v); chk("R7 force while disabled", v, 8'h5A);
        exp_type = 8'hA7; exp_cas = 3'd7;
        hwrite(2'd0, 1'b1);
        run_seq();
        irq = 1'b0;
        hread(2'd2, v); chk("R8 re-enabled capture", v, 8'hA7);
        hread(2'd3, v); chk("R8 re-enabled cascade", v, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule